// File: doc/BRIEF.md
# Audio Serial Frame Transmitter with Clock and Strobe Dividers

This block turns pairs of parallel audio samples (left and right) into one serial data line, timed by a bit clock and a word strobe. All of its logic runs on the system clock, which also serves as the oversampling master clock. In master role it divides the master clock down to a bit clock, then divides the bit clock down to a word strobe, and drives both onto its pins. In slave role it leaves those pins undriven and takes the bit clock and word strobe from an external device, passing each through a two-stage synchronizer.

The parallel-to-serial core is the same in both roles. It watches the selected bit clock for its launch edge and the selected word strobe for entry into the left-channel level. A small state machine has three states. `ST_WAIT` waits for the first frame trigger after reset. `ST_DATA` sends sample bits. `ST_PAD` fills the rest of a frame longer than two samples with zeros. The transitions are:

- WAIT→DATA on a trigger.
- DATA→DATA on a trigger, which reloads the samples.
- DATA→PAD at a launch edge once the last sample bit has been sent.
- PAD→DATA on a trigger.

Each trigger loads a fresh sample pair when one is offered. If none is offered, the block repeats the previous pair and raises an underrun flag.

Top module: `aud_frame_tx`

## Requirements
- R1: In master role the bit clock period is `sck_div`+1 system clocks. Its high phase lasts ceil((`sck_div`+1)/2) clocks, so for an odd divisor the high phase is one clock longer than the low phase.
- R2: In master role with `sck_div` = 0, the bit clock is held high from the first clock after reset, and no data bit is shifted.
- R3: In master role a frame lasts `ws_div`+1 bit clock periods. The word strobe stays at the left-channel level for the first ceil((`ws_div`+1)/2) bits. The word strobe changes only together with a bit clock launch transition.
- R4: `ws_left_high` = 1 means a high word strobe marks the left channel; 0 means a low one does. A frame starts at the first launch edge at which the word strobe has entered the left-channel level. After reset, the driven strobe sits at the right-channel level.
- R5: Each frame carries {left, right} most significant bit first. Bits past 2×`SW` in a frame are zero. A frame shorter than 2×`SW` carries only its leading bits. The first bit of the next frame follows the last bit of the previous one directly.
- R6: `launch_rise` = 1 makes data change after rising bit clock edges, and 0 after falling ones. In master role `sd_out` changes exactly one system clock after the launch transition at the pin and holds through the opposite edge (for `sck_div` ≥ 3).
- R7: At a frame start with `sample_valid` high, `left_in`/`right_in` are taken. `sample_ack` pulses for that single clock, and it is never high while `sample_valid` is low.
- R8: At a frame start with `sample_valid` low, the last accepted pair is sent again and `underrun` goes high. `underrun` clears at the next frame start that accepts a pair.
- R9: In slave role `sck_out`, `ws_out` and `pins_drive` stay low. Data is timed by `sck_in`/`ws_in` after synchronization, with the same frame format.
- R10: During reset `sck_out` and `sd_out` are 0, `sample_ack` and `underrun` are 0, and `ws_out` is at the right-channel level in master role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1: generate bit clock and word strobe; 0: receive them |
| sck_div | input | SCKW | Bit clock divisor minus one |
| ws_div | input | WSW | Frame length in bits minus one |
| ws_left_high | input | 1 | Word strobe level that marks the left channel |
| launch_rise | input | 1 | 1: data launched on rising bit clock edge; 0: falling |
| left_in | input | SW | Left sample offered |
| right_in | input | SW | Right sample offered |
| sample_valid | input | 1 | A sample pair is offered |
| sample_ack | output | 1 | Offered pair taken this clock |
| underrun | output | 1 | Current frame repeats the previous pair |
| sck_in | input | 1 | Bit clock from an external master |
| ws_in | input | 1 | Word strobe from an external master |
| sck_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Generated word strobe |
| pins_drive | output | 1 | Output enable for the clock and strobe pins |
| sd_out | output | 1 | Serial data |

## Verification
A corrupted bit counter or a state stuck in `ST_PAD` shows up within one frame: zeros appear where sample bits belong, or the padding lands in the wrong place in the word captured at the receive edges. A wrong divider count shows up within one bit clock period as a wrong high or period length on `sck_out`, and within one frame as a wrong bit count between left-level entries of `ws_out`. A lost or wrong launch edge shows as `sd_out` changing on the receive edge, so the bench reads shifted data within the same frame. A broken sample holding register shows up only in the first underrun frame, as data that differs from the last accepted pair.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    // States of the serializer control
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_DATA = 2'd1,
        ST_PAD  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/aud_tx_sync.sv
module aud_tx_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/aud_tx_bclk_gen.sv
module aud_tx_bclk_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         launch_rise,
    input  logic [W-1:0] div,
    output logic         bclk,
    output logic         launch_nxt
);

    localparam int HW = W + 1;

    logic [W-1:0]  cnt_q, cnt_d;
    logic          run_q;
    logic          bclk_d;
    logic [HW-1:0] half;

    // high phase covers counts below half, half rounded up
    always_comb begin
        half = ({1'b0, div} + HW'(2)) >> 1;
        if (!run_q || (cnt_q >= div)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        bclk_d     = ({1'b0, cnt_d} < half);
        launch_nxt = en && (bclk_d != bclk) && (bclk_d == launch_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            bclk  <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            bclk  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= 1'b1;
            bclk  <= bclk_d;
        end
    end

endmodule

// File: rtl/aud_tx_ws_gen.sv
module aud_tx_ws_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] div,
    output logic         left_phase
);

    localparam int HW = W + 1;

    logic [W-1:0]  cnt_q, cnt_d;
    logic          run_q;
    logic          left_d;
    logic [HW-1:0] half;

    always_comb begin
        half = ({1'b0, div} + HW'(2)) >> 1;
        if (!run_q || (cnt_q >= div)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        left_d = ({1'b0, cnt_d} < half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            run_q      <= 1'b0;
            left_phase <= 1'b0;
        end else if (!en) begin
            cnt_q      <= '0;
            run_q      <= 1'b0;
            left_phase <= 1'b0;
        end else if (tick) begin
            cnt_q      <= cnt_d;
            run_q      <= 1'b1;
            left_phase <= left_d;
        end
    end

endmodule

// File: rtl/aud_tx_core.sv
module aud_tx_core
    import aud_tx_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          ws_s,
    input  logic          launch_rise,
    input  logic          ws_left_high,
    input  logic [SW-1:0] left_in,
    input  logic [SW-1:0] right_in,
    input  logic          sample_valid,
    output logic          sample_ack,
    output logic          underrun,
    output logic          sd_out
);

    localparam int FW  = 2 * SW;
    localparam int BCW = $clog2(FW + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FW - 1);

    tx_state_e      st_q, st_d;
    logic           sck_p;
    logic           ws_last_left;
    logic [FW-1:0]  sreg;
    logic [BCW-1:0] bit_cnt;
    logic [SW-1:0]  hold_l, hold_r;
    logic           urun_q;

    logic launch, is_left, trigger, do_load, do_shift;

    always_comb begin
        launch  = (sck_s != sck_p) && (sck_s == launch_rise);
        is_left = (ws_s == ws_left_high);
        trigger = launch && is_left && !ws_last_left;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and control strobes
    always_comb begin
        st_d     = st_q;
        do_load  = 1'b0;
        do_shift = 1'b0;
        unique case (st_q)
            ST_WAIT: begin
                if (trigger) begin
                    st_d    = ST_DATA;
                    do_load = 1'b1;
                end
            end
            ST_DATA: begin
                if (trigger) begin
                    do_load = 1'b1;
                end else if (launch) begin
                    do_shift = 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        st_d = ST_PAD;
                    end
                end
            end
            ST_PAD: begin
                if (trigger) begin
                    st_d    = ST_DATA;
                    do_load = 1'b1;
                end
            end
            default: begin
                st_d = ST_WAIT;
            end
        endcase
    end

    // edge history and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p        <= 1'b0;
            ws_last_left <= 1'b1;
            sreg         <= '0;
            bit_cnt      <= '0;
            hold_l       <= '0;
            hold_r       <= '0;
            urun_q       <= 1'b0;
        end else begin
            sck_p <= sck_s;
            if (launch) begin
                ws_last_left <= is_left;
            end
            if (do_load) begin
                bit_cnt <= '0;
                if (sample_valid) begin
                    hold_l <= left_in;
                    hold_r <= right_in;
                    sreg   <= {left_in, right_in};
                    urun_q <= 1'b0;
                end else begin
                    sreg   <= {hold_l, hold_r};
                    urun_q <= 1'b1;
                end
            end else if (do_shift) begin
                sreg    <= {sreg[FW-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (st_q == ST_PAD) begin
                sreg <= '0;
            end
        end
    end

    assign sample_ack = do_load && sample_valid;
    assign underrun   = urun_q;
    assign sd_out     = sreg[FW-1];

endmodule

// File: rtl/aud_frame_tx.sv
module aud_frame_tx #(
    parameter int SW   = 16,
    parameter int SCKW = 8,
    parameter int WSW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master_en,
    input  logic [SCKW-1:0] sck_div,
    input  logic [WSW-1:0]  ws_div,
    input  logic            ws_left_high,
    input  logic            launch_rise,
    input  logic [SW-1:0]   left_in,
    input  logic [SW-1:0]   right_in,
    input  logic            sample_valid,
    output logic            sample_ack,
    output logic            underrun,
    input  logic            sck_in,
    input  logic            ws_in,
    output logic            sck_out,
    output logic            ws_out,
    output logic            pins_drive,
    output logic            sd_out
);

    logic [1:0] pin_sync;
    logic       bclk, bclk_launch_nxt;
    logic       left_phase;
    logic       ws_gen_pin;
    logic       sck_sel, ws_sel;

    aud_tx_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, ws_in}),
        .q     (pin_sync)
    );

    aud_tx_bclk_gen #(.W(SCKW)) u_bclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (master_en),
        .launch_rise (launch_rise),
        .div         (sck_div),
        .bclk        (bclk),
        .launch_nxt  (bclk_launch_nxt)
    );

    aud_tx_ws_gen #(.W(WSW)) u_ws (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (master_en),
        .tick       (bclk_launch_nxt),
        .div        (ws_div),
        .left_phase (left_phase)
    );

    always_comb begin
        ws_gen_pin = left_phase ? ws_left_high : !ws_left_high;
        sck_sel    = master_en ? bclk : pin_sync[1];
        ws_sel     = master_en ? ws_gen_pin : pin_sync[0];
    end

    aud_tx_core #(.SW(SW)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_s        (sck_sel),
        .ws_s         (ws_sel),
        .launch_rise  (launch_rise),
        .ws_left_high (ws_left_high),
        .left_in      (left_in),
        .right_in     (right_in),
        .sample_valid (sample_valid),
        .sample_ack   (sample_ack),
        .underrun     (underrun),
        .sd_out       (sd_out)
    );

    assign sck_out    = bclk;
    assign ws_out     = master_en && ws_gen_pin;
    assign pins_drive = master_en;

endmodule

// File: rtl/aud_frame_tx_chk.sv
module aud_frame_tx_chk #(
    parameter int SCKW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            master_en,
    input logic [SCKW-1:0] sck_div,
    input logic            launch_rise,
    input logic            sample_valid,
    input logic            sample_ack,
    input logic            underrun,
    input logic            sck_out,
    input logic            ws_out,
    input logic            sd_out
);

    // R6
    sd_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n || !master_en)
        $changed(sd_out) |-> ($past(sck_out) == launch_rise) && ($past(sck_out, 2) != launch_rise));

    // R3
    ws_with_launch_chk: assert property (@(posedge clk) disable iff (!rst_n || !master_en)
        $changed(ws_out) |-> $changed(sck_out) && (sck_out == launch_rise));

    // R2
    div_zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && (sck_div == '0)) |=> sck_out);

    // R7
    ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ack |-> sample_valid);

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ack |=> !sample_ack);

    // R8
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> !$past(sample_valid));

    // R8
    underrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(underrun) |-> $past(sample_ack));

endmodule

bind aud_frame_tx aud_frame_tx_chk #(.SCKW(SCKW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_en    (master_en),
    .sck_div      (sck_div),
    .launch_rise  (launch_rise),
    .sample_valid (sample_valid),
    .sample_ack   (sample_ack),
    .underrun     (underrun),
    .sck_out      (sck_out),
    .ws_out       (ws_out),
    .sd_out       (sd_out)
);

// File: tb/test_aud_frame_tx.sv
module test_aud_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b1;
    logic [7:0]  sck_div = 8'd3;
    logic [7:0]  ws_div = 8'd31;
    logic        ws_left_high = 1'b1;
    logic        launch_rise = 1'b0;
    logic [15:0] left_in = '0;
    logic [15:0] right_in = '0;
    logic        sample_valid = 1'b0;
    logic        sample_ack, underrun, sck_out, ws_out, pins_drive, sd_out;
    logic        sck_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        slave_run = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int ack_cnt = 0;

    always #4 clk = !clk;

    aud_frame_tx i_aud_frame_tx (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .sck_div(sck_div),
        .ws_div(ws_div), .ws_left_high(ws_left_high), .launch_rise(launch_rise),
        .left_in(left_in), .right_in(right_in), .sample_valid(sample_valid),
        .sample_ack(sample_ack), .underrun(underrun), .sck_in(sck_in), .ws_in(ws_in),
        .sck_out(sck_out), .ws_out(ws_out), .pins_drive(pins_drive), .sd_out(sd_out)
    );

    logic obs_sck, obs_ws;
    assign obs_sck = master_en ? sck_out : sck_in;
    assign obs_ws  = master_en ? ws_out : ws_in;

    always @(negedge clk) if (sample_ack) ack_cnt++;

    // external master model: 16-clock bit period, 32-bit frame, left high
    int sl_cnt = 0;
    int sl_bit = 0;
    always @(posedge clk) begin
        #2;
        if (!slave_run) begin
            sck_in = 1'b0; ws_in = 1'b0; sl_cnt = 0; sl_bit = 31;
        end else begin
            sl_cnt = (sl_cnt + 1) % 16;
            if (sl_cnt == 0) sck_in = 1'b1;
            if (sl_cnt == 8) begin
                sck_in = 1'b0;
                sl_bit = (sl_bit + 1) % 32;
                ws_in  = (sl_bit < 16);
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rx_bit(output logic b, output logic w);
        logic prev;
        bit   hit;
        prev = obs_sck;
        hit  = 1'b0;
        while (!hit) begin
            @(negedge clk);
            hit  = (obs_sck != prev) && (obs_sck == !launch_rise);
            prev = obs_sck;
        end
        b = sd_out;
        w = obs_ws;
    endtask

    task automatic capture(output logic [63:0] word, output int n, output int nleft);
        logic b, w;
        bit   pl, st;
        pl = 1'b1;
        st = 1'b0;
        while (!st) begin
            rx_bit(b, w);
            st = (w == ws_left_high) && !pl;
            pl = (w == ws_left_high);
        end
        word = '0; n = 0; nleft = 0;
        st = 1'b0;
        while (!st) begin
            word = {word[62:0], b};
            n++;
            if (w == ws_left_high) nleft++;
            rx_bit(b, w);
            st = (w == ws_left_high) && !pl;
            pl = (w == ws_left_high);
        end
    endtask

    task automatic measure_bclk(output int hi, output int per);
        logic prev;
        bit   r;
        @(negedge clk);
        prev = sck_out;
        r = 1'b0;
        while (!r) begin
            @(negedge clk);
            r = !prev && sck_out;
            prev = sck_out;
        end
        hi = 0; per = 0; r = 1'b0;
        while (!r) begin
            if (sck_out) hi++;
            per++;
            prev = sck_out;
            @(negedge clk);
            r = !prev && sck_out;
        end
    endtask

    function automatic logic [63:0] frame_exp(input logic [15:0] l, input logic [15:0] r, input int n);
        logic [63:0] base;
        base = {32'b0, l, r};
        return (n >= 32) ? (base << (n - 32)) : (base >> (32 - n));
    endfunction

    // sck_div, ws_div, left level, launch on rise, left, right
    localparam int NV = 6;
    localparam logic [49:0] VEC [NV] = '{
        {8'd3, 8'd31, 1'b1, 1'b0, 16'hA5C3, 16'h1E2F},
        {8'd5, 8'd31, 1'b0, 1'b0, 16'h8001, 16'h7FFE},
        {8'd4, 8'd31, 1'b1, 1'b1, 16'hF00F, 16'h0FF0},
        {8'd3, 8'd47, 1'b1, 1'b0, 16'h1234, 16'hABCD},
        {8'd3, 8'd23, 1'b0, 1'b1, 16'hCAFE, 16'hBEEF},
        {8'd6, 8'd63, 1'b1, 1'b0, 16'h5555, 16'hAAAA}
    };

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] word;
        int n, nl, hi, per;

        // reset state (R10, R4)
        repeat (3) @(negedge clk);
        check(sck_out == 1'b0, "R10 sck_out in reset", sck_out, 0);
        check(sd_out == 1'b0, "R10 sd_out in reset", sd_out, 0);
        check(sample_ack == 1'b0 && underrun == 1'b0, "R10 ack/underrun in reset", {sample_ack, underrun}, 0);
        check(ws_out == !ws_left_high, "R4 R10 ws right level in reset", ws_out, !ws_left_high);

        sample_valid = 1'b1;
        for (int v = 0; v < NV; v++) begin
            rst_n = 1'b0;
            {sck_div, ws_div, ws_left_high, launch_rise, left_in, right_in} = VEC[v];
            do_reset();
            measure_bclk(hi, per);
            check(per == int'(sck_div) + 1, $sformatf("R1 period vec%0d", v), per, int'(sck_div) + 1);
            check(hi == (int'(sck_div) + 2) / 2, $sformatf("R1 high phase vec%0d", v), hi, (int'(sck_div) + 2) / 2);
            capture(word, n, nl);
            ack_cnt = 0;
            capture(word, n, nl);
            check(n == int'(ws_div) + 1, $sformatf("R3 frame bits vec%0d", v), n, int'(ws_div) + 1);
            check(nl == (int'(ws_div) + 2) / 2, $sformatf("R3 R4 left bits vec%0d", v), nl, (int'(ws_div) + 2) / 2);
            check(word == frame_exp(left_in, right_in, n), $sformatf("R5,R6 frame data vec%0d", v),
                  word, frame_exp(left_in, right_in, n));
            check(ack_cnt >= 1, $sformatf("R7 ack seen vec%0d", v), ack_cnt, 1);
            check(underrun == 1'b0, $sformatf("R8 no underrun vec%0d", v), underrun, 0);
        end

        // R8: missing sample repeats previous pair
        rst_n = 1'b0;
        {sck_div, ws_div, ws_left_high, launch_rise, left_in, right_in} = VEC[0];
        do_reset();
        capture(word, n, nl);
        sample_valid = 1'b0;
        left_in = 16'h0F0F; right_in = 16'hF0F0;
        ack_cnt = 0;
        capture(word, n, nl);
        check(word == frame_exp(16'hA5C3, 16'h1E2F, 32), "R8 repeated pair", word, frame_exp(16'hA5C3, 16'h1E2F, 32));
        check(underrun == 1'b1, "R8 underrun raised", underrun, 1);
        check(ack_cnt == 0, "R7 no ack without valid", ack_cnt, 0);
        sample_valid = 1'b1;
        capture(word, n, nl);
        capture(word, n, nl);
        check(word == frame_exp(16'h0F0F, 16'hF0F0, 32), "R8 new pair after underrun", word, frame_exp(16'h0F0F, 16'hF0F0, 32));
        check(underrun == 1'b0, "R8 underrun cleared", underrun, 0);

        // R2: zero divisor holds bit clock high
        rst_n = 1'b0;
        sck_div = 8'd0;
        do_reset();
        @(negedge clk);
        begin
            int bad = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (!sck_out || sd_out) bad++;
            end
            check(bad == 0, "R2 bit clock stuck high, no data", bad, 0);
        end

        // R9: slave role
        rst_n = 1'b0;
        master_en = 1'b0;
        ws_left_high = 1'b1; launch_rise = 1'b0; sck_div = 8'd3;
        left_in = 16'h3C5A; right_in = 16'h9669;
        do_reset();
        slave_run = 1'b1;
        capture(word, n, nl);
        capture(word, n, nl);
        check(n == 32, "R9 slave frame bits", n, 32);
        check(word == frame_exp(16'h3C5A, 16'h9669, 32), "R9 slave frame data", word, frame_exp(16'h3C5A, 16'h9669, 32));
        check(!sck_out && !ws_out && !pins_drive, "R9 pins not driven", {sck_out, ws_out, pins_drive}, 0);
        slave_run = 1'b0;

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule